// File: doc/BRIEF.md
# FIFO DMA Request Handshake Generator

This block turns the fill levels of a 16-entry transmit FIFO and a 16-entry receive FIFO into transfer requests for a flow-controlling DMA engine. Each direction has a burst-request line and a single-request line. The burst length is fixed at four entries. A direction raises a burst when enough data or enough free space exists for four transfers and its watermark condition holds. It raises a single request when at least one transfer, but fewer than four, is possible.

Each request is a registered level. Once raised, it stays high until the DMA engine pulses the matching acknowledge. It then stays low for at least one cycle. This keeps the engine from counting the same request twice. While one kind of request is pending in a direction, the other kind is not raised in that direction. Each direction has its own enable. When the enable is clear, that direction's requests are forced low on the next clock.

The two watermarks are held in registers. A write strobe loads them from the configuration inputs. Reset loads them with default values, four for both directions. The block has no data path, so it has no valid/ready interface. Every pin is a plain level or a one-cycle strobe, and all pins are sampled on the rising clock edge.

Top module: `dmareq_gen`

## Requirements
- R1: A synchronous active-low reset clears all four request outputs on the next edge. It also loads both watermark registers with 4. After reset, a transmit burst needs a level of 4 or less, and a receive burst needs a level of 5 or more.
- R2: When `cfg_wr` is high at an edge, both 4-bit watermark registers load `tx_wm_in` and `rx_wm_in`. A request decision taken at that same edge still uses the previous watermark values. The new values take effect from the next edge.
- R3: The transmit burst request is raised one edge after the following holds: `tx_level` is at or below the transmit watermark, and 16 - `tx_level` is at least 4.
- R4: The transmit single request is raised when the free space, 16 - `tx_level`, is 1, 2 or 3. A full transmit FIFO (level 16) raises neither request.
- R5: The receive burst request is raised when `rx_level` is at least the receive watermark + 1 and also at least 4. With watermark 15, this means exactly 16 entries.
- R6: The receive single request is raised when `rx_level` is 1, 2 or 3. An empty receive FIFO raises neither request.
- R7: A raised request stays high until an edge where its own acknowledge is high, even if the level no longer meets its condition. An acknowledge of the other kind has no effect. So does an acknowledge with no request pending.
- R8: At the edge where a request is acknowledged, that request goes low and stays low for at least the following cycle, even if its condition still holds.
- R9: The burst and single request of one direction are never high together. Neither kind is raised at an edge where the other kind is pending at that edge.
- R10: While a direction's enable is low, its two requests are low from the next edge on.
- R11: The transmit and receive directions act independently. Both can hold requests at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Watermark register load strobe |
| tx_wm_in | input | 4 | Transmit watermark value to load |
| rx_wm_in | input | 4 | Receive watermark value to load (burst at value + 1 entries) |
| tx_en | input | 1 | Transmit request enable |
| rx_en | input | 1 | Receive request enable |
| tx_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_burst_ack | input | 1 | DMA acknowledge of the transmit burst request |
| tx_single_ack | input | 1 | DMA acknowledge of the transmit single request |
| rx_burst_ack | input | 1 | DMA acknowledge of the receive burst request |
| rx_single_ack | input | 1 | DMA acknowledge of the receive single request |
| tx_burst_req | output | 1 | Transmit burst (four-transfer) request |
| tx_single_req | output | 1 | Transmit single-transfer request |
| rx_burst_req | output | 1 | Receive burst (four-transfer) request |
| rx_single_req | output | 1 | Receive single-transfer request |

## Verification
Two things can fall on the same edge: retiring one kind of request and qualifying the other kind in the same direction. For example, the single acknowledge can arrive while the level has already moved into the burst range. The bench provokes this by pulsing that acknowledge in the very cycle the level changes. It then expects both lines low for that cycle and the burst line high only one cycle later. The bench also pulses an acknowledge together with a condition that still holds, and expects the mandatory low cycle before the request returns.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  typedef struct packed {
    logic burst;
    logic single;
  } req_pair_t;
endpackage

// File: rtl/dmareq_wm_reg.sv
module dmareq_wm_reg #(
  parameter int WM_W      = 4,
  parameter int TX_WM_RST = 4,
  parameter int RX_WM_RST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [WM_W-1:0] tx_wm_in,
  input  logic [WM_W-1:0] rx_wm_in,
  output logic [WM_W-1:0] tx_wm_q,
  output logic [WM_W-1:0] rx_wm_q
);
  localparam logic [WM_W-1:0] TX_RST_V = WM_W'(TX_WM_RST);
  localparam logic [WM_W-1:0] RX_RST_V = WM_W'(RX_WM_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wm_q <= TX_RST_V;
      rx_wm_q <= RX_RST_V;
    end else if (cfg_wr) begin
      tx_wm_q <= tx_wm_in;
      rx_wm_q <= rx_wm_in;
    end
  end

  // R2: a strobe makes the new value visible one edge later
  p_wm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (tx_wm_q == $past(tx_wm_in)) && (rx_wm_q == $past(rx_wm_in)));

  p_wm_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(tx_wm_q) && $stable(rx_wm_q));

  // R1: reset loads the defaults
  p_wm_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (tx_wm_q == TX_RST_V) && (rx_wm_q == RX_RST_V));
endmodule

// File: rtl/dmareq_level_decode.sv
module dmareq_level_decode #(
  parameter dmareq_pkg::dir_e DIR = dmareq_pkg::DIR_TX,
  parameter int DEPTH = 16,
  parameter int WM_W  = 4,
  parameter int BURST = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]      level,
  input  logic [WM_W-1:0]       wm,
  output dmareq_pkg::req_pair_t want
);
  localparam logic [LVL_W:0] DEPTH_X = (LVL_W + 1)'(DEPTH);
  localparam logic [LVL_W:0] BURST_X = (LVL_W + 1)'(BURST);
  localparam logic [LVL_W:0] ONE_X   = (LVL_W + 1)'(1);

  logic [LVL_W:0] lvl_x;
  logic [LVL_W:0] wm_x;

  assign lvl_x = {1'b0, level};
  assign wm_x  = (LVL_W + 1)'(wm);

  generate
    if (DIR == dmareq_pkg::DIR_TX) begin : g_tx
      logic [LVL_W:0] room;
      assign room = DEPTH_X - lvl_x;
      // R3: watermark met and room for a whole burst
      assign want.burst  = (lvl_x <= wm_x) && (room >= BURST_X);
      // R4: some room, but less than a burst
      assign want.single = (room >= ONE_X) && (room < BURST_X);
    end else begin : g_rx
      // R5: watermark is offset by one, and a whole burst must be present
      assign want.burst  = (lvl_x >= wm_x + ONE_X) && (lvl_x >= BURST_X);
      // R6: some data, but less than a burst
      assign want.single = (lvl_x >= ONE_X) && (lvl_x < BURST_X);
    end
  endgenerate
endmodule

// File: rtl/dmareq_handshake.sv
module dmareq_handshake (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  dmareq_pkg::req_pair_t want,
  input  logic                  ack_burst,
  input  logic                  ack_single,
  output logic                  burst_req,
  output logic                  single_req
);
  logic burst_d;
  logic single_d;

  always_comb begin
    if (burst_req) burst_d = !ack_burst;
    else           burst_d = want.burst && !single_req;
    if (single_req) single_d = !ack_single;
    else            single_d = want.single && !want.burst && !burst_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      burst_req  <= 1'b0;
      single_req <= 1'b0;
    end else begin
      burst_req  <= burst_d;
      single_req <= single_d;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> !burst_req && !single_req);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_req && single_req));

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && en && !ack_burst |=> burst_req);

  p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    single_req && en && !ack_single |=> single_req);

  p_burst_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && ack_burst |=> !burst_req);

  p_single_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    single_req && ack_single |=> !single_req);

  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !burst_req && !single_req);

  p_burst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_req) |-> $past(want.burst) && !$past(single_req));

  p_single_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(single_req) |-> $past(want.single) && !$past(burst_req));
endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen #(
  parameter int DEPTH     = 16,
  parameter int WM_W      = 4,
  parameter int BURST     = 4,
  parameter int TX_WM_RST = 4,
  parameter int RX_WM_RST = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [WM_W-1:0]              tx_wm_in,
  input  logic [WM_W-1:0]              rx_wm_in,
  input  logic                         tx_en,
  input  logic                         rx_en,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic                         tx_burst_ack,
  input  logic                         tx_single_ack,
  input  logic                         rx_burst_ack,
  input  logic                         rx_single_ack,
  output logic                         tx_burst_req,
  output logic                         tx_single_req,
  output logic                         rx_burst_req,
  output logic                         rx_single_req
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WM_W-1:0]       tx_wm_q;
  logic [WM_W-1:0]       rx_wm_q;
  dmareq_pkg::req_pair_t tx_want;
  dmareq_pkg::req_pair_t rx_want;

  dmareq_wm_reg #(
    .WM_W(WM_W), .TX_WM_RST(TX_WM_RST), .RX_WM_RST(RX_WM_RST)
  ) u_wm (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .tx_wm_in(tx_wm_in), .rx_wm_in(rx_wm_in),
    .tx_wm_q(tx_wm_q), .rx_wm_q(rx_wm_q)
  );

  dmareq_level_decode #(
    .DIR(dmareq_pkg::DIR_TX), .DEPTH(DEPTH), .WM_W(WM_W), .BURST(BURST), .LVL_W(LVL_W)
  ) u_tx_dec (
    .level(tx_level), .wm(tx_wm_q), .want(tx_want)
  );

  dmareq_level_decode #(
    .DIR(dmareq_pkg::DIR_RX), .DEPTH(DEPTH), .WM_W(WM_W), .BURST(BURST), .LVL_W(LVL_W)
  ) u_rx_dec (
    .level(rx_level), .wm(rx_wm_q), .want(rx_want)
  );

  dmareq_handshake u_tx_hs (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .want(tx_want),
    .ack_burst(tx_burst_ack), .ack_single(tx_single_ack),
    .burst_req(tx_burst_req), .single_req(tx_single_req)
  );

  dmareq_handshake u_rx_hs (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .want(rx_want),
    .ack_burst(rx_burst_ack), .ack_single(rx_single_ack),
    .burst_req(rx_burst_req), .single_req(rx_single_req)
  );

  // R11: a receive request only starts from receive-side inputs
  p_rx_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_burst_req) |-> $past(rx_en) && ($past(rx_level) >= LVL_W'(BURST)));

  p_level_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));
endmodule

// File: tb/tb_dmareq_gen.sv
module tb_dmareq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] tx_wm_in = 4'd0;
  logic [3:0] rx_wm_in = 4'd0;
  logic       tx_en = 1'b0;
  logic       rx_en = 1'b0;
  logic [4:0] tx_level = 5'd16;
  logic [4:0] rx_level = 5'd0;
  logic       tx_burst_ack = 1'b0;
  logic       tx_single_ack = 1'b0;
  logic       rx_burst_ack = 1'b0;
  logic       rx_single_ack = 1'b0;
  logic       tx_burst_req;
  logic       tx_single_req;
  logic       rx_burst_req;
  logic       rx_single_req;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  dmareq_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .tx_wm_in(tx_wm_in), .rx_wm_in(rx_wm_in),
    .tx_en(tx_en), .rx_en(rx_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_burst_ack(tx_burst_ack), .tx_single_ack(tx_single_ack),
    .rx_burst_ack(rx_burst_ack), .rx_single_ack(rx_single_ack),
    .tx_burst_req(tx_burst_req), .tx_single_req(tx_single_req),
    .rx_burst_req(rx_burst_req), .rx_single_req(rx_single_req)
  );

  // {tx_en, rx_en, tx_level, rx_level, ack{tb,ts,rb,rs}, expect{tb,ts,rb,rs}}
  localparam int NV = 30;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'd16, 5'd0,  4'b0000, 4'b0000}, // idle, full tx, empty rx (R4 R6)
    {1'b1, 1'b1, 5'd0,  5'd0,  4'b0000, 4'b1000}, // R3 tx burst raised
    {1'b1, 1'b1, 5'd8,  5'd0,  4'b0000, 4'b1000}, // R7 held past condition
    {1'b1, 1'b1, 5'd8,  5'd0,  4'b1000, 4'b0000}, // R7 acked
    {1'b1, 1'b1, 5'd2,  5'd0,  4'b0000, 4'b1000}, // R3
    {1'b1, 1'b1, 5'd2,  5'd0,  4'b1000, 4'b0000}, // R8 low after ack
    {1'b1, 1'b1, 5'd2,  5'd0,  4'b0000, 4'b1000}, // R8 back after gap
    {1'b1, 1'b1, 5'd14, 5'd0,  4'b0100, 4'b1000}, // R7 wrong ack ignored, R9 blocked
    {1'b1, 1'b1, 5'd14, 5'd0,  4'b1000, 4'b0000},
    {1'b1, 1'b1, 5'd14, 5'd0,  4'b0000, 4'b0100}, // R4 free 2
    {1'b1, 1'b1, 5'd0,  5'd0,  4'b0000, 4'b0100}, // R9 burst blocked
    {1'b1, 1'b1, 5'd0,  5'd0,  4'b0100, 4'b0000}, // R9 same-edge ack
    {1'b1, 1'b1, 5'd0,  5'd0,  4'b0000, 4'b1000},
    {1'b1, 1'b1, 5'd16, 5'd0,  4'b1000, 4'b0000},
    {1'b1, 1'b1, 5'd16, 5'd4,  4'b0000, 4'b0000}, // R5 level 4 below wm+1
    {1'b1, 1'b1, 5'd16, 5'd5,  4'b0000, 4'b0010}, // R5
    {1'b1, 1'b1, 5'd16, 5'd2,  4'b0001, 4'b0010}, // R7
    {1'b1, 1'b1, 5'd16, 5'd2,  4'b0010, 4'b0000},
    {1'b1, 1'b1, 5'd16, 5'd2,  4'b0000, 4'b0001}, // R6
    {1'b1, 1'b1, 5'd16, 5'd16, 4'b0001, 4'b0000},
    {1'b1, 1'b1, 5'd16, 5'd16, 4'b0000, 4'b0010},
    {1'b1, 1'b0, 5'd16, 5'd16, 4'b0000, 4'b0000}, // R10 drop
    {1'b1, 1'b0, 5'd16, 5'd16, 4'b0000, 4'b0000}, // R10 stays low
    {1'b1, 1'b1, 5'd0,  5'd16, 4'b0000, 4'b1010}, // R11 both
    {1'b0, 1'b1, 5'd0,  5'd16, 4'b0000, 4'b0010}, // R10 R11
    {1'b1, 1'b1, 5'd16, 5'd0,  4'b0010, 4'b0000},
    {1'b1, 1'b1, 5'd16, 5'd0,  4'b0010, 4'b0000}, // R7 stray ack
    {1'b1, 1'b1, 5'd15, 5'd1,  4'b0000, 4'b0101}, // R4 R6 R11
    {1'b1, 1'b1, 5'd15, 5'd1,  4'b0101, 4'b0000},
    {1'b1, 1'b1, 5'd16, 5'd0,  4'b0000, 4'b0000}
  };

  task automatic step(input logic et, input logic er, input logic [4:0] lt,
                      input logic [4:0] lr, input logic [3:0] ack,
                      input logic [3:0] exp, input string tag);
    logic [3:0] got;
    tx_en = et; rx_en = er; tx_level = lt; rx_level = lr;
    {tx_burst_ack, tx_single_ack, rx_burst_ack, rx_single_ack} = ack;
    @(posedge clk);
    @(negedge clk);
    {tx_burst_ack, tx_single_ack, rx_burst_ack, rx_single_ack} = 4'b0000;
    cfg_wr = 1'b0;
    got = {tx_burst_req, tx_single_req, rx_burst_req, rx_single_req};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: requests {tb,ts,rb,rs} actual %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    step(1'b1, 1'b1, 5'd0, 5'd16, 4'b0000, 4'b0000, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17:13], VEC[i][12:8],
           VEC[i][7:4], VEC[i][3:0], $sformatf("vector %0d", i));
    end

    // R1: reset mid-request, then default watermarks
    step(1'b1, 1'b1, 5'd0, 5'd16, 4'b0000, 4'b1010, "R11 setup");
    rst_n = 1'b0;
    step(1'b1, 1'b1, 5'd0, 5'd16, 4'b0000, 4'b0000, "R1 reset clears");
    rst_n = 1'b1;
    step(1'b1, 1'b1, 5'd5, 5'd0, 4'b0000, 4'b0000, "R1 tx wm 4 level 5");
    step(1'b1, 1'b1, 5'd4, 5'd0, 4'b0000, 4'b1000, "R1 tx wm 4 level 4");
    step(1'b1, 1'b1, 5'd16, 5'd4, 4'b1000, 4'b0000, "R1 rx wm 4 level 4");
    step(1'b1, 1'b1, 5'd16, 5'd5, 4'b0000, 4'b0010, "R1 rx wm 4 level 5");
    step(1'b1, 1'b1, 5'd16, 5'd0, 4'b0010, 4'b0000, "R1 rx ack");

    // R2: load takes effect one edge later
    cfg_wr = 1'b1; tx_wm_in = 4'd15; rx_wm_in = 4'd0;
    step(1'b1, 1'b1, 5'd16, 5'd4, 4'b0000, 4'b0000, "R2 load edge uses old wm");
    step(1'b1, 1'b1, 5'd16, 5'd4, 4'b0000, 4'b0010, "R2 new rx wm 0");
    step(1'b1, 1'b1, 5'd16, 5'd0, 4'b0010, 4'b0000, "R2 rx ack");
    step(1'b1, 1'b1, 5'd12, 5'd0, 4'b0000, 4'b1000, "R3 tx wm 15 free 4");
    step(1'b1, 1'b1, 5'd16, 5'd0, 4'b1000, 4'b0000, "R3 ack");
    step(1'b1, 1'b1, 5'd13, 5'd0, 4'b0000, 4'b0100, "R4 free 3 single");
    step(1'b1, 1'b1, 5'd16, 5'd0, 4'b0100, 4'b0000, "R4 ack");

    // R5: watermark 15 needs all 16 entries
    cfg_wr = 1'b1; tx_wm_in = 4'd0; rx_wm_in = 4'd15;
    step(1'b1, 1'b1, 5'd16, 5'd0, 4'b0000, 4'b0000, "R2 load wm 15");
    step(1'b1, 1'b1, 5'd16, 5'd15, 4'b0000, 4'b0000, "R5 level 15 wm 15");
    step(1'b1, 1'b1, 5'd16, 5'd16, 4'b0000, 4'b0010, "R5 level 16 wm 15");
    step(1'b1, 1'b1, 5'd1, 5'd0, 4'b0010, 4'b0000, "R3 tx wm 0 level 1");
    step(1'b1, 1'b1, 5'd0, 5'd0, 4'b0000, 4'b1000, "R3 tx wm 0 level 0");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule